// File: doc/BRIEF.md
# Edge-Interrupt GPIO Port

This block is one 8-bit general-purpose I/O port for a microcontroller-style peripheral bus. Software reaches it through a small byte-wide register window. Each pin has its own direction, output value, function select, secondary (touch-sense) select and pull-resistor enable. When the port is built with interrupt support, each pin also has a rising/falling edge select, an interrupt enable and a sticky interrupt flag. The OR of all enabled flags drives one interrupt request line.

Pad inputs pass through a two-flop synchroniser. The synchronised value is what software reads back and what the edge detector watches. The pull-resistor direction is not held in a register of its own. It comes from the output-value bit of any pin that is an input with its pull enabled.

A port built without interrupt support has no flag, edge-select or enable storage. Those offsets read zero and its request line stays low.

Top module: `gpio_port`

## Requirements
- R1: After reset every register reads 0, and `pad_oe`, `pad_out`, `pull_en`, `pull_up`, `func_sel`, `func_sel2` and `irq` are all 0.
- R2: The register offsets on `addr` are fixed: 0 input, 1 output value, 2 direction, 3 flags, 4 edge select, 5 interrupt enable, 6 function select, 7 pull enable, 8 secondary select. A write to offsets 1, 2, 4, 5, 6, 7 or 8 takes effect at the next rising edge and reads back the written byte. Offsets 9 to 15 read 0 and store nothing.
- R3: Offset 0 returns the pad inputs, sampled by two flops, so a pad change is visible two rising edges later. Writes to offset 0 change no register.
- R4: `pad_oe` equals the direction register (1 = output), `pad_out` the output-value register, `func_sel` the function select and `func_sel2` the secondary select.
- R5: `pull_en` is high for a bit whose pull enable is 1 and whose direction is 0. `pull_up` is that bit's output value while `pull_en` is high (1 = pull up, 0 = pull down) and 0 otherwise.
- R6: With edge select 0, a low-to-high change on the synchronised input sets the bit's flag. A high-to-low change does not.
- R7: With edge select 1, a high-to-low change sets the flag. A low-to-high change does not.
- R8: A flag stays set until software writes 0 to it. Writing 1 sets it.
- R9: A flag is set by its edge whether or not its enable is 1. `irq` is high while any bit has both flag and enable set.
- R10: When an edge and a software write of 0 to the same flag fall in the same cycle, the flag ends up set.
- R11: With parameter `HAS_IRQ` = 0, offsets 3, 4 and 5 read 0 whatever is written, and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_out | output | 8 | Pad drive values |
| pad_oe | output | 8 | Pad output enables |
| pull_en | output | 8 | Pull-resistor enables |
| pull_up | output | 8 | Pull direction, 1 = up |
| func_sel | output | 8 | Function select per pin |
| func_sel2 | output | 8 | Secondary (touch-sense) select per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
A register write presented before a rising edge is visible on `rd_data` and on the pad controls right after that edge. `irq` follows the flag and enable registers in the same cycle. A pad change reaches the input register two edges later and sets a flag on the third.

The bench changes inputs on falling edges and counts rising edges explicitly before it samples. It also samples one edge early, to show that the input value and the flag have not yet moved. The collision case puts the clearing write exactly on the edge that sets the flag.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [3:0] {
        OFF_IN   = 4'd0,
        OFF_OUT  = 4'd1,
        OFF_DIR  = 4'd2,
        OFF_IFG  = 4'd3,
        OFF_IES  = 4'd4,
        OFF_IE   = 4'd5,
        OFF_SEL  = 4'd6,
        OFF_REN  = 4'd7,
        OFF_SEL2 = 4'd8
    } reg_off_e;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  out_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic [WIDTH-1:0]  sel_q,
    output logic [WIDTH-1:0]  ren_q,
    output logic [WIDTH-1:0]  sel2_q
);

    logic wr_out, wr_dir, wr_sel, wr_ren, wr_sel2;

    always_comb begin
        wr_out  = wr_en && (addr == ADDR_W'(OFF_OUT));
        wr_dir  = wr_en && (addr == ADDR_W'(OFF_DIR));
        wr_sel  = wr_en && (addr == ADDR_W'(OFF_SEL));
        wr_ren  = wr_en && (addr == ADDR_W'(OFF_REN));
        wr_sel2 = wr_en && (addr == ADDR_W'(OFF_SEL2));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q  <= '0;
            dir_q  <= '0;
            sel_q  <= '0;
            ren_q  <= '0;
            sel2_q <= '0;
        end else begin
            if (wr_out)  out_q  <= wr_data;
            if (wr_dir)  dir_q  <= wr_data;
            if (wr_sel)  sel_q  <= wr_data;
            if (wr_ren)  ren_q  <= wr_data;
            if (wr_sel2) sel2_q <= wr_data;
        end
    end

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_port_pkg::*;
#(
    parameter int WIDTH  = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic [WIDTH-1:0]  in_sync,
    output logic [WIDTH-1:0]  ifg_q,
    output logic [WIDTH-1:0]  ies_q,
    output logic [WIDTH-1:0]  ie_q,
    output logic              irq
);

    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] edge_hit;
    logic [WIDTH-1:0] ifg_d;
    logic             wr_ifg, wr_ies, wr_ie;

    always_comb begin
        wr_ifg = wr_en && (addr == ADDR_W'(OFF_IFG));
        wr_ies = wr_en && (addr == ADDR_W'(OFF_IES));
        wr_ie  = wr_en && (addr == ADDR_W'(OFF_IE));
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic rise, fall;
        always_comb begin
            rise        = in_sync[i] & ~prev_q[i];
            fall        = ~in_sync[i] & prev_q[i];
            edge_hit[i] = ies_q[i] ? fall : rise;
            // a detected edge wins over a software write in the same cycle
            ifg_d[i]    = (wr_ifg ? wr_data[i] : ifg_q[i]) | edge_hit[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            ifg_q  <= '0;
            ies_q  <= '0;
            ie_q   <= '0;
        end else begin
            prev_q <= in_sync;
            ifg_q  <= ifg_d;
            if (wr_ies) ies_q <= wr_data;
            if (wr_ie)  ie_q  <= wr_data;
        end
    end

    assign irq = |(ifg_q & ie_q);

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int ADDR_W  = 4,
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [WIDTH-1:0]  wr_data,
    output logic [WIDTH-1:0]  rd_data,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pull_en,
    output logic [WIDTH-1:0]  pull_up,
    output logic [WIDTH-1:0]  func_sel,
    output logic [WIDTH-1:0]  func_sel2,
    output logic              irq
);

    logic [WIDTH-1:0] in_sync;
    logic [WIDTH-1:0] out_q, dir_q, sel_q, ren_q, sel2_q;
    logic [WIDTH-1:0] ifg_q, ies_q, ie_q;

    gpio_port_sync #(.WIDTH(WIDTH)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .out_q   (out_q),
        .dir_q   (dir_q),
        .sel_q   (sel_q),
        .ren_q   (ren_q),
        .sel2_q  (sel2_q)
    );

    if (HAS_IRQ) begin : g_irq
        gpio_port_irq #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_en),
            .addr    (addr),
            .wr_data (wr_data),
            .in_sync (in_sync),
            .ifg_q   (ifg_q),
            .ies_q   (ies_q),
            .ie_q    (ie_q),
            .irq     (irq)
        );
    end else begin : g_no_irq
        assign ifg_q = '0;
        assign ies_q = '0;
        assign ie_q  = '0;
        assign irq   = 1'b0;
    end

    always_comb begin
        case (addr)
            ADDR_W'(OFF_IN):   rd_data = in_sync;
            ADDR_W'(OFF_OUT):  rd_data = out_q;
            ADDR_W'(OFF_DIR):  rd_data = dir_q;
            ADDR_W'(OFF_IFG):  rd_data = ifg_q;
            ADDR_W'(OFF_IES):  rd_data = ies_q;
            ADDR_W'(OFF_IE):   rd_data = ie_q;
            ADDR_W'(OFF_SEL):  rd_data = sel_q;
            ADDR_W'(OFF_REN):  rd_data = ren_q;
            ADDR_W'(OFF_SEL2): rd_data = sel2_q;
            default:           rd_data = '0;
        endcase
    end

    always_comb begin
        pad_out   = out_q;
        pad_oe    = dir_q;
        func_sel  = sel_q;
        func_sel2 = sel2_q;
        pull_en   = ren_q & ~dir_q;
        pull_up   = out_q & pull_en;
    end

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int ADDR_W  = 4,
    parameter bit HAS_IRQ = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic [WIDTH-1:0]  out_q,
    input logic [WIDTH-1:0]  dir_q,
    input logic [WIDTH-1:0]  ie_q,
    input logic [WIDTH-1:0]  ifg_q,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pull_en,
    input logic              irq
);

    a_r3_in_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_IN)) |=>
            ($stable(out_q) && $stable(dir_q) && $stable(ie_q)));

    a_r4_dir_drives_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_DIR)) |=> (pad_oe == $past(wr_data)));

    a_r5_pull_only_inputs: assert property (@(posedge clk) disable iff (!rst_n)
        ((pull_en & pad_oe) == '0));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(OFF_IFG)) |=>
            ((ifg_q & $past(ifg_q)) == $past(ifg_q)));

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFF_IE) && wr_data == '0) |=> !irq);

    a_r11_no_irq_variant: assert property (@(posedge clk) disable iff (!rst_n)
        (!HAS_IRQ) |-> !irq);

endmodule

bind gpio_port gpio_port_chk #(
    .WIDTH   (WIDTH),
    .ADDR_W  (ADDR_W),
    .HAS_IRQ (HAS_IRQ)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .out_q   (out_q),
    .dir_q   (dir_q),
    .ie_q    (ie_q),
    .ifg_q   (ifg_q),
    .pad_oe  (pad_oe),
    .pull_en (pull_en),
    .irq     (irq)
);

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] rd_data, pad_out, pad_oe, pull_en, pull_up, func_sel, func_sel2;
    logic       irq;
    logic [7:0] rd_data_n, pad_out_n, pad_oe_n, pull_en_n, pull_up_n, fsel_n, fsel2_n;
    logic       irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pull_en(pull_en), .pull_up(pull_up), .func_sel(func_sel),
        .func_sel2(func_sel2), .irq(irq)
    );

    gpio_port #(.HAS_IRQ(1'b0)) u_dut_noirq (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data_n), .pad_in(pad_in), .pad_out(pad_out_n), .pad_oe(pad_oe_n),
        .pull_en(pull_en_n), .pull_up(pull_up_n), .func_sel(fsel_n),
        .func_sel2(fsel2_n), .irq(irq_n)
    );

    // {offset, write data, expected read-back}
    localparam logic [19:0] VEC [10] = '{
        {4'd1, 8'hA6, 8'hA6},
        {4'd2, 8'h3C, 8'h3C},
        {4'd4, 8'hF0, 8'hF0},
        {4'd5, 8'h0F, 8'h0F},
        {4'd6, 8'h81, 8'h81},
        {4'd7, 8'h66, 8'h66},
        {4'd8, 8'h18, 8'h18},
        {4'd0, 8'h55, 8'h00},
        {4'd9, 8'hFF, 8'h00},
        {4'd15, 8'hFF, 8'h00}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [3:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic wait_edges(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin : watchdog
        #100000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] v;
        wait_edges(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), v);
            check("R1 reset register", v, 8'h00);
        end
        check("R1 reset pad_oe", pad_oe, 8'h00);
        check("R1 reset pull_en", pull_en, 8'h00);
        check("R1 reset irq", {7'd0, irq}, 8'h00);

        // R2 / R3 table of write and read-back
        for (int i = 0; i < 10; i++) begin
            wr(VEC[i][19:16], VEC[i][15:8]);
            rd(VEC[i][19:16], v);
            check("R2 R3 register table", v, VEC[i][7:0]);
        end

        // R4 and R5 pad controls
        check("R4 pad_oe", pad_oe, 8'h3C);
        check("R4 pad_out", pad_out, 8'hA6);
        check("R4 func_sel", func_sel, 8'h81);
        check("R4 func_sel2", func_sel2, 8'h18);
        check("R5 pull_en", pull_en, 8'h42);
        check("R5 pull_up", pull_up, 8'h02);

        // disarm edges before moving pads
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h00);

        // R3 input timing: visible after two edges
        pad_in = 8'h5A;
        @(negedge clk);
        rd(4'd0, v);
        check("R3 input one edge", v, 8'h00);
        @(negedge clk);
        rd(4'd0, v);
        check("R3 input two edges", v, 8'h5A);
        pad_in = 8'h00;
        wait_edges(4);
        wr(4'd3, 8'h00);
        rd(4'd3, v);
        check("R8 clear by write 0", v, 8'h00);

        // R6 rising edge sets with select 0, flag on third edge
        pad_in = 8'h01;
        wait_edges(2);
        rd(4'd3, v);
        check("R6 flag not yet", v, 8'h00);
        @(negedge clk);
        rd(4'd3, v);
        check("R6 rising sets", v, 8'h01);
        wr(4'd3, 8'h00);
        pad_in = 8'h00;
        wait_edges(4);
        rd(4'd3, v);
        check("R6 falling ignored", v, 8'h00);

        // R7 falling edge with select 1
        wr(4'd4, 8'h02);
        pad_in = 8'h02;
        wait_edges(4);
        rd(4'd3, v);
        check("R7 rising ignored", v, 8'h00);
        pad_in = 8'h00;
        wait_edges(4);
        rd(4'd3, v);
        check("R7 falling sets", v, 8'h02);

        // R9 flag set while disabled, irq follows enable
        check("R9 irq low while disabled", {7'd0, irq}, 8'h00);
        wr(4'd5, 8'h02);
        check("R9 irq high when enabled", {7'd0, irq}, 8'h01);
        wr(4'd5, 8'h01);
        check("R9 irq low other bit", {7'd0, irq}, 8'h00);

        // R8 software set, sticky, clear
        wr(4'd3, 8'h80);
        rd(4'd3, v);
        check("R8 write replaces flags", v, 8'h80);
        wr(4'd5, 8'h80);
        check("R8 R9 soft flag raises irq", {7'd0, irq}, 8'h01);
        wait_edges(5);
        rd(4'd3, v);
        check("R8 flag sticky", v, 8'h80);
        wr(4'd3, 8'h00);
        check("R8 clear drops irq", {7'd0, irq}, 8'h00);

        // R10 edge and clearing write in the same cycle
        wr(4'd4, 8'h00);
        pad_in = 8'h04;
        wait_edges(2);
        addr = 4'd3; wr_data = 8'h00; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        rd(4'd3, v);
        check("R10 edge beats clear", v, 8'h04);

        // R11 variant without interrupt support
        wr(4'd4, 8'hFF);
        wr(4'd5, 8'hFF);
        wr(4'd3, 8'hFF);
        check("R9 main irq all set", {7'd0, irq}, 8'h01);
        for (int a = 3; a < 6; a++) begin
            addr = 4'(a);
            #0.5;
            check("R11 no-irq offsets read 0", rd_data_n, 8'h00);
        end
        check("R11 no-irq irq low", {7'd0, irq_n}, 8'h00);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule